// File: doc/BRIEF.md
# Out-of-Order Worker Pool with In-Order Result Release

This block raises the throughput of a stateless per-request operation by spreading requests over a pool of identical worker units whose processing time changes from request to request. When a request is accepted, it first claims the next free entry of a circular reorder buffer, in arrival order. It is then handed, together with the index of that entry, to an idle worker. Workers finish in any order. A finished worker presents its result and the entry index to a round-robin arbiter that owns the buffer's only write port. A worker that loses arbitration keeps its result and stays occupied until it is granted.

Results leave the buffer only from its head, in arrival order. An entry that completed early waits behind an older entry that has not yet completed. The input and output streams both use a valid/ready handshake. The workers are behavioural models: each returns the bitwise complement of its request word, after a delay taken from the word's low bits. Requests share no state, so the reordering is invisible at the output.

Top module: `vl_stream_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: Every accepted request yields exactly one output word, equal to the bitwise complement of its in_data. Output words appear in the order in which the requests were accepted.
- R3: Buffer entries are claimed in acceptance order. While the oldest outstanding request is unfinished, out_valid stays 0, even if younger requests have already finished.
- R4: An accepted request is given to an idle worker. When all NUM_WORKERS workers are occupied, in_ready is 0.
- R5: A request whose in_data bits [2:0] hold the value k takes k+1 cycles in its worker. On an otherwise idle block, out_valid rises k+1 clock edges after the edge that accepted the request.
- R6: The buffer has one write port. Workers finishing in the same cycle are granted one per cycle in round-robin order. A worker that is not granted keeps its result pending, and no result is lost.
- R7: When ROB_DEPTH requests are outstanding (accepted and not yet taken at the output), in_ready is 0 and no further request is accepted.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R9: Each result depends only on its own request word. The same word gives the same result at any position in the stream and under any mix of neighbouring latencies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request word offered |
| in_ready | output | 1 | Block can take a request this cycle |
| in_data | input | DATA_W | Request word; bits [LAT_BITS-1:0] select the worker delay |
| out_valid | output | 1 | Result at the buffer head is available |
| out_ready | input | 1 | Consumer takes the head result |
| out_data | output | DATA_W | Result word, in request order |

## Verification
Two things can fall in the same cycle: several workers finishing together and contending for the single buffer write port, and the head draining while a younger entry is being written. The bench provokes the first by issuing requests on consecutive cycles with latencies 4, 3, 2 and 1, so that all four workers finish on the same edge. It then checks that exactly four results come out, in request order, with the correct complements. The second is provoked by sweeping all 64 pairs of latencies with a gated out_ready pattern. Every output word is judged against an arithmetically computed expectation queue.

// File: rtl/vlsd_pkg.sv
package vlsd_pkg;

   // Worker model phases
   typedef enum logic {
      WK_IDLE = 1'b0,
      WK_RUN  = 1'b1
   } worker_state_e;

   // Smallest index width able to address n items (at least 1)
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/vlsd_worker.sv
module vlsd_worker
   import vlsd_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned TAG_W    = 3,
   parameter int unsigned LAT_BITS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] start_data,
   input  logic [TAG_W-1:0]  start_tag,
   input  logic              ack,
   output logic              busy,
   output logic              done,
   output logic [TAG_W-1:0]  res_tag,
   output logic [DATA_W-1:0] res_data
);

   worker_state_e       state_q;
   logic [LAT_BITS-1:0] remain_q;

   // Remaining cycles are loaded as delay-1, so a code of k finishes after k+1 cycles
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= WK_IDLE;
         remain_q <= '0;
         res_tag  <= '0;
         res_data <= '0;
      end else begin
         unique case (state_q)
            WK_IDLE: begin
               if (start) begin
                  state_q  <= WK_RUN;
                  remain_q <= start_data[LAT_BITS-1:0];
                  res_tag  <= start_tag;
                  res_data <= ~start_data;
               end
            end
            WK_RUN: begin
               if (remain_q != '0) begin
                  remain_q <= remain_q - 1'b1;
               end else if (ack) begin
                  state_q <= WK_IDLE;
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end

   assign busy = (state_q == WK_RUN);
   assign done = (state_q == WK_RUN) && (remain_q == '0);

endmodule

// File: rtl/vlsd_rr_arb.sv
module vlsd_rr_arb
   import vlsd_pkg::*;
#(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);

   localparam int unsigned IDX_W = idx_width(N);

   generate
      if (N == 1) begin : g_single
         assign grant = req;
      end else begin : g_rr
         logic [IDX_W-1:0] ptr_q;
         logic [IDX_W-1:0] win_idx;
         logic             any_req;

         // Search starts at the pointer and wraps around the request vector
         always_comb begin
            int sel;
            grant   = '0;
            win_idx = '0;
            any_req = 1'b0;
            for (int off = 0; off < int'(N); off++) begin
               sel = (int'(ptr_q) + off) % int'(N);
               if (!any_req && req[sel]) begin
                  grant[sel] = 1'b1;
                  win_idx    = IDX_W'(sel);
                  any_req    = 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ptr_q <= '0;
            end else if (any_req) begin
               ptr_q <= (win_idx == IDX_W'(N - 1)) ? '0 : win_idx + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vlsd_rob.sv
module vlsd_rob #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   output logic [PTR_W-1:0]  alloc_tag,
   output logic              full,
   output logic [CNT_W-1:0]  count,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   output logic              head_valid,
   output logic [DATA_W-1:0] head_data,
   input  logic              pop
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("vlsd_rob: DEPTH must be a power of two and at least 2");
   end

   logic [PTR_W-1:0]  head_q;
   logic [PTR_W-1:0]  tail_q;
   logic [CNT_W-1:0]  count_q;
   logic [DEPTH-1:0]  filled_q;
   logic [DATA_W-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (alloc) tail_q <= tail_q + 1'b1;
         if (pop)   head_q <= head_q + 1'b1;
         count_q <= count_q + CNT_W'(alloc) - CNT_W'(pop);
      end
   end

   // Per-entry completion flag and payload
   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            filled_q[s] <= 1'b0;
         end else if (wr_en && wr_tag == PTR_W'(s)) begin
            filled_q[s] <= 1'b1;
         end else if (pop && head_q == PTR_W'(s)) begin
            filled_q[s] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && wr_tag == PTR_W'(s)) store_q[s] <= wr_data;
      end
   end

   assign alloc_tag  = tail_q;
   assign count      = count_q;
   assign full       = (count_q == CNT_W'(DEPTH));
   assign head_valid = filled_q[head_q];
   assign head_data  = store_q[head_q];

endmodule

// File: rtl/vl_stream_dispatch.sv
module vl_stream_dispatch #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NUM_WORKERS = 4,
   parameter int unsigned ROB_DEPTH   = 8,
   parameter int unsigned LAT_BITS    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);

   localparam int unsigned TAG_W = $clog2(ROB_DEPTH);
   localparam int unsigned CNT_W = $clog2(ROB_DEPTH + 1);

   if (NUM_WORKERS < 1) begin : g_bad_workers
      $error("vl_stream_dispatch: NUM_WORKERS must be at least 1");
   end
   if (LAT_BITS < 1 || LAT_BITS > DATA_W) begin : g_bad_lat
      $error("vl_stream_dispatch: LAT_BITS must lie in 1..DATA_W");
   end

   logic [NUM_WORKERS-1:0] busy_vec;
   logic [NUM_WORKERS-1:0] done_vec;
   logic [NUM_WORKERS-1:0] pick_vec;
   logic [NUM_WORKERS-1:0] start_vec;
   logic [NUM_WORKERS-1:0] grant_vec;
   logic [TAG_W-1:0]       res_tag  [NUM_WORKERS];
   logic [DATA_W-1:0]      res_data [NUM_WORKERS];

   logic              accept;
   logic              rob_full;
   logic [TAG_W-1:0]  new_tag;
   logic [CNT_W-1:0]  rob_count;
   logic              wr_en;
   logic [TAG_W-1:0]  wr_tag;
   logic [DATA_W-1:0] wr_data;
   logic              pop;

   // Lowest-numbered idle worker takes the next request
   always_comb begin
      logic found;
      pick_vec = '0;
      found    = 1'b0;
      for (int w = 0; w < int'(NUM_WORKERS); w++) begin
         if (!found && !busy_vec[w]) begin
            pick_vec[w] = 1'b1;
            found       = 1'b1;
         end
      end
   end

   assign in_ready  = !rob_full && !(&busy_vec);
   assign accept    = in_valid && in_ready;
   assign start_vec = accept ? pick_vec : '0;

   for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_worker
      vlsd_worker #(
         .DATA_W  (DATA_W),
         .TAG_W   (TAG_W),
         .LAT_BITS(LAT_BITS)
      ) u_worker (
         .clk       (clk),
         .rst_n     (rst_n),
         .start     (start_vec[w]),
         .start_data(in_data),
         .start_tag (new_tag),
         .ack       (grant_vec[w]),
         .busy      (busy_vec[w]),
         .done      (done_vec[w]),
         .res_tag   (res_tag[w]),
         .res_data  (res_data[w])
      );
   end

   vlsd_rr_arb #(
      .N(NUM_WORKERS)
   ) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (done_vec),
      .grant(grant_vec)
   );

   // Single write port: route the granted worker's result
   always_comb begin
      wr_tag  = '0;
      wr_data = '0;
      for (int w = 0; w < int'(NUM_WORKERS); w++) begin
         if (grant_vec[w]) begin
            wr_tag  = res_tag[w];
            wr_data = res_data[w];
         end
      end
   end
   assign wr_en = |grant_vec;

   vlsd_rob #(
      .DATA_W(DATA_W),
      .DEPTH (ROB_DEPTH)
   ) u_rob (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (accept),
      .alloc_tag (new_tag),
      .full      (rob_full),
      .count     (rob_count),
      .wr_en     (wr_en),
      .wr_tag    (wr_tag),
      .wr_data   (wr_data),
      .head_valid(out_valid),
      .head_data (out_data),
      .pop       (pop)
   );

   assign pop = out_valid && out_ready;

endmodule

// File: rtl/vlsd_check.sv
module vlsd_check #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NUM_WORKERS = 4,
   parameter int unsigned ROB_DEPTH   = 8,
   localparam int unsigned CNT_W = $clog2(ROB_DEPTH + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [DATA_W-1:0]      out_data,
   input logic [CNT_W-1:0]       rob_count,
   input logic [NUM_WORKERS-1:0] busy_vec,
   input logic [NUM_WORKERS-1:0] done_vec,
   input logic [NUM_WORKERS-1:0] grant_vec
);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (rob_count < CNT_W'(ROB_DEPTH))); // R7

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_count == CNT_W'(ROB_DEPTH)) |-> !in_ready); // R7

   AST_POOL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy_vec) |-> !in_ready); // R4

   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_vec)); // R6

   AST_GRANT_FINISHED: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_vec & ~done_vec) == '0)); // R6

   for (genvar w = 0; w < NUM_WORKERS; w++) begin : g_hold
      AST_LOSER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (done_vec[w] && !grant_vec[w]) |=> done_vec[w]); // R6
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

endmodule

bind vl_stream_dispatch vlsd_check #(
   .DATA_W     (DATA_W),
   .NUM_WORKERS(NUM_WORKERS),
   .ROB_DEPTH  (ROB_DEPTH)
) u_check (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data),
   .rob_count(rob_count),
   .busy_vec (busy_vec),
   .done_vec (done_vec),
   .grant_vec(grant_vec)
);

// File: tb/vl_stream_dispatch_test.sv
`timescale 1ns/100ps
module vl_stream_dispatch_test;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic          in_ready;
   logic [DW-1:0] in_data;
   logic          out_valid;
   logic          out_ready;
   logic [DW-1:0] out_data;

   int n_vec  = 0;
   int n_fail = 0;
   int wr_ptr = 0;
   int rd_ptr = 0;
   int out_mode = 0;
   logic [DW-1:0] exp_q [1024];

   always #2.5 clk = ~clk;

   vl_stream_dispatch #(
      .DATA_W(DW), .NUM_WORKERS(4), .ROB_DEPTH(8), .LAT_BITS(3)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Consumer handshake pattern
   initial begin
      int cyc = 0;
      out_ready = 1'b1;
      forever begin
         @(negedge clk);
         cyc++;
         case (out_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'b0;
            default: out_ready = ((cyc % 3) != 2) && ((cyc % 7) != 4);
         endcase
      end
   end

   // Scoreboard: expectation pushed at acceptance, compared at release (R2, R9)
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            if (in_valid && in_ready) begin
               exp_q[wr_ptr % 1024] = ~in_data;
               wr_ptr++;
            end
            if (out_valid && out_ready) begin
               if (rd_ptr < wr_ptr)
                  chk(out_data == exp_q[rd_ptr % 1024], "R2 R9 order/value",
                      int'(out_data), int'(exp_q[rd_ptr % 1024]));
               else
                  chk(1'b0, "R2 spurious output", int'(out_data), 0);
               rd_ptr++;
            end
         end
      end
   end

   task automatic send(input logic [DW-1:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_drain();
      int guard = 0;
      while (rd_ptr != wr_ptr && guard < 5000) begin
         @(negedge clk);
         #1;
         guard++;
      end
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rd_ptr, wr_ptr);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      int base;
      logic [DW-1:0] held;
      logic [31:0] lcg;
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

      // R5: per-request delay for every code
      for (int k = 0; k < 8; k++) begin
         int edges;
         send(16'h5A00 | DW'(k));
         idle();
         #1;
         edges = 0;
         while (!out_valid && edges < 20) begin
            @(negedge clk);
            #1;
            edges++;
         end
         chk(edges == k + 1, "R5 latency", edges, k + 1);
         wait_drain();
      end

      // R4: four long requests occupy the whole pool
      for (int i = 0; i < 4; i++) send(16'h1107 + DW'(i << 8));
      idle();
      #1;
      chk(in_ready == 1'b0, "R4 pool busy stalls input", int'(in_ready), 0);
      wait_drain();

      // R3: younger short request waits behind older long one
      send(16'h0007);
      send(16'h0010);
      idle();
      repeat (4) @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R3 head incomplete holds output", int'(out_valid), 0);
      while (!out_valid) begin @(negedge clk); #1; end
      chk(out_data == ~16'h0007, "R3 oldest released first", int'(out_data), int'(~16'h0007));
      wait_drain();

      // R6: four workers finish on the same edge, twice with different consumers
      for (int pass = 0; pass < 2; pass++) begin
         out_mode = pass * 2;
         base = rd_ptr;
         send(16'h0103); send(16'h0202); send(16'h0301); send(16'h0400);
         idle();
         wait_drain();
         chk(rd_ptr - base == 4, "R6 all colliding results delivered", rd_ptr - base, 4);
      end

      // R7, R8: consumer stalled, buffer fills
      out_mode = 1;
      @(negedge clk);
      base = rd_ptr;
      for (int i = 0; i < 8; i++) send(16'h0A00 + DW'(i << 4));
      idle();
      repeat (3) @(negedge clk);
      #1;
      chk(in_ready == 1'b0, "R7 full buffer stalls input", int'(in_ready), 0);
      chk(out_valid == 1'b1, "R8 head presented", int'(out_valid), 1);
      chk(out_data == ~16'h0A00, "R8 head value", int'(out_data), int'(~16'h0A00));
      held = out_data;
      in_valid = 1'b1; in_data = 16'hBEEF;
      repeat (4) @(negedge clk);
      #1;
      chk(out_valid == 1'b1 && out_data == held, "R8 output held stable", int'(out_data), int'(held));
      chk(wr_ptr - base == 8, "R7 no acceptance while full", wr_ptr - base, 8);
      in_valid = 1'b0;
      out_mode = 0;
      wait_drain();
      chk(rd_ptr - base == 8, "R7 stalled results drained", rd_ptr - base, 8);

      // Sweep of all latency pairs under a gated consumer (R2, R6, R9)
      out_mode = 2;
      for (int a = 0; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            send(DW'((a << 12) | (b << 8) | a));
            send(DW'((b << 12) | (a << 8) | b));
            send(DW'(16'h00F0 | ((a + b) % 8)));
         end
      end
      idle();
      wait_drain();

      // Long pseudo-random stream with gaps
      lcg = 32'h1234_5678;
      for (int i = 0; i < 300; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         send(lcg[23:8]);
         if (lcg[30:28] == 3'd0) idle();
      end
      idle();
      wait_drain();
      chk(rd_ptr == wr_ptr, "R2 every request answered", rd_ptr, wr_ptr);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule